// File: doc/BRIEF.md
# MII Management Status Poller

This block keeps track of an external PHY's status word with no help from the host. While polling is enabled it derives a management clock from the system clock and sends read frames on the serial management line, one after another. Each frame carries the preamble, start and opcode fields, the selected PHY address and the address of the register being read. After the header it releases the data line and shifts in the sixteen-bit reply. The word it reads is placed on an output. A strobe marks every poll that returns a value different from the previous one, so logic downstream can react when the link goes up or down.

The spacing between frames is self-timed. A three-bit code chooses an idle gap of zero, or of 32 up to 2048 management-clock periods, counted between the end of one frame and the start of the next. By default the register read is register 1, the status register. A parameter selects a different register. The bidirectional data pin is shown as a separate output value, output enable and input, to match an external tri-state pad.

Top module: `mdio_autopoll`

## Requirements
- R1: While `poll_en` is low, `mdc` stays low and `mdio_oe` stays low, and no frame is sent.
- R2: While polling, `mdc` has a period of `MDC_DIV` system clocks, and each high phase lasts `MDC_DIV/2` clocks.
- R3: `mdio_o` and `mdio_oe` change only on clock edges after which `mdc` is low. They never change on an edge where `mdc` rises or stays high.
- R4: Each frame drives 46 bits, MSB first, with `mdio_oe` high: 32 ones, then 01, then 10, then the 5-bit `phy_addr`, then the 5-bit register address `POLL_REG` (default 1). It then holds `mdio_oe` low for 2 turnaround bits and 16 data bits.
- R5: The 16 data bits are sampled from `mdio_i` on the rising `mdc` edges of the data field, MSB first. The word becomes `status_word` when the frame ends.
- R6: The gap code `gap_sel` is read at the end of each frame. Code 0 starts the next frame at once. Code c (1 to 7) leaves 2^(c+4) rising `mdc` edges between the last data bit and the first header bit of the next frame.
- R7: `status_chg` is high for exactly the one clock in which `status_word` takes a value different from its previous one. It stays low when a poll returns the same value.
- R8: `link_up` equals bit 2 of `status_word`.
- R9: Dropping `poll_en` in the middle of a frame aborts it. On the next clock `mdc` and `mdio_oe` are low, and `status_word` keeps its old value.
- R10: On the first clock edge at which `poll_en` is seen high after being low, a frame starts: `mdio_oe` and `mdio_o` go high while `mdc` is low.
- R11: After reset, `mdc`, `mdio_o`, `mdio_oe`, `status_word`, `status_chg` and `link_up` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_en | input | 1 | Enables automatic polling |
| phy_addr | input | 5 | Address of the PHY to poll |
| gap_sel | input | 3 | Code for the idle gap between frames |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven to the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Data value read from the pad |
| status_word | output | 16 | Last word read from the PHY |
| status_chg | output | 1 | One-clock pulse when the word changes |
| link_up | output | 1 | Link bit of the last word |

## Verification
The bound checker watches four things on every clock. It checks that the pins stay quiet while polling is off. It checks that the data line and its enable move only while the management clock is low. It checks the length of each clock high phase. It checks that the status word moves only together with the change strobe, and always to a new value.

The remaining properties show up only over whole frames, so the bench's PHY model has to demonstrate them. These are: the header contents and their bit order, and the gap measured for every code. They also include the MSB-first capture of the reply, whether a strobe appears when a poll returns a repeated word, the start on the first clock after enabling, and the abort that leaves the old status in place.

// File: rtl/mdio_poll_pkg.sv
package mdio_poll_pkg;

    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned DATA_W   = 16;
    localparam int unsigned PRE_BITS = 32;
    localparam int unsigned TA_BITS  = 2;
    localparam int unsigned HDR_BITS = PRE_BITS + 4 + 2 * ADDR_W;
    localparam int unsigned CNT_W    = $clog2(HDR_BITS);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HDR,
        PH_TURN,
        PH_DATA
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic [HDR_BITS-1:0] hdr;
        logic [DATA_W-1:0]   rx;
        logic                mdo;
        logic                oe;
    } seq_state_t;

    // Header in wire order: preamble, start 01, read opcode 10, PHY, register.
    function automatic logic [HDR_BITS-1:0] make_header(
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] regad
    );
        return {{PRE_BITS{1'b1}}, 2'b01, 2'b10, phy, regad};
    endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int unsigned DIV = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);

    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned CW   = $clog2(DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d     = div_q;
        rise_tick = 1'b0;
        fall_tick = 1'b0;
        if (!run) begin
            div_d.cnt = '0;
            div_d.mdc = 1'b0;
        end else if (div_q.cnt == CW'(DIV - 1)) begin
            div_d.cnt = '0;
            div_d.mdc = 1'b0;
            fall_tick = 1'b1;
        end else begin
            div_d.cnt = div_q.cnt + CW'(1);
            if (div_q.cnt == CW'(HALF - 1)) begin
                div_d.mdc = 1'b1;
                rise_tick = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign mdc = div_q.mdc;

endmodule

// File: rtl/poll_gap_timer.sv
module poll_gap_timer #(
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned BASE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fall_tick,
    input  logic             frame_done,
    input  logic [SEL_W-1:0] gap_sel,
    output logic             go
);

    localparam int unsigned MAX_LOG2 = (1 << SEL_W) - 1 + BASE_LOG2;
    localparam int unsigned GAP_W    = MAX_LOG2 + 1;

    typedef struct packed {
        logic             fresh;
        logic             counting;
        logic [GAP_W-1:0] gcnt;
    } gap_t;

    gap_t gap_d, gap_q;
    logic [GAP_W-1:0] gap_len;

    always_comb begin
        if (gap_sel == '0) begin
            gap_len = '0;
        end else begin
            gap_len = GAP_W'(1) << (int'(gap_sel) + BASE_LOG2);
        end
    end

    always_comb begin
        gap_d = gap_q;
        go    = 1'b0;
        if (!run) begin
            gap_d.fresh    = 1'b1;
            gap_d.counting = 1'b0;
            gap_d.gcnt     = '0;
        end else if (gap_q.fresh) begin
            go          = 1'b1;
            gap_d.fresh = 1'b0;
        end else if (frame_done) begin
            if (gap_len == '0) begin
                go = 1'b1;
            end else begin
                gap_d.counting = 1'b1;
                gap_d.gcnt     = gap_len;
            end
        end else if (gap_q.counting && fall_tick) begin
            if (gap_q.gcnt == GAP_W'(1)) begin
                go             = 1'b1;
                gap_d.counting = 1'b0;
                gap_d.gcnt     = '0;
            end else begin
                gap_d.gcnt = gap_q.gcnt - GAP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '{fresh: 1'b1, counting: 1'b0, gcnt: '0};
        end else begin
            gap_q <= gap_d;
        end
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_poll_pkg::*;
#(
    parameter int unsigned POLL_REG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              go,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              frame_done,
    output logic [DATA_W-1:0] rx_word
);

    localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(POLL_REG);

    seq_state_t s_d, s_q;
    logic [HDR_BITS-1:0] fresh_hdr;

    assign fresh_hdr  = make_header(phy_addr, REG_ADDR);
    assign frame_done = (s_q.ph == PH_DATA) && fall_tick
                        && (s_q.cnt == CNT_W'(DATA_W - 1));

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.ph  = PH_IDLE;
            s_d.cnt = '0;
            s_d.mdo = 1'b0;
            s_d.oe  = 1'b0;
        end else begin
            if ((s_q.ph == PH_DATA) && rise_tick) begin
                s_d.rx = {s_q.rx[DATA_W-2:0], mdio_i};
            end
            unique case (s_q.ph)
                PH_IDLE: begin
                    if (go) begin
                        s_d.ph  = PH_HDR;
                        s_d.cnt = '0;
                        s_d.hdr = fresh_hdr;
                        s_d.mdo = fresh_hdr[HDR_BITS-1];
                        s_d.oe  = 1'b1;
                    end
                end
                PH_HDR: begin
                    if (fall_tick) begin
                        if (s_q.cnt == CNT_W'(HDR_BITS - 1)) begin
                            s_d.ph  = PH_TURN;
                            s_d.cnt = '0;
                            s_d.mdo = 1'b0;
                            s_d.oe  = 1'b0;
                        end else begin
                            s_d.cnt = s_q.cnt + CNT_W'(1);
                            s_d.hdr = s_q.hdr << 1;
                            s_d.mdo = s_q.hdr[HDR_BITS-2];
                        end
                    end
                end
                PH_TURN: begin
                    if (fall_tick) begin
                        if (s_q.cnt == CNT_W'(TA_BITS - 1)) begin
                            s_d.ph  = PH_DATA;
                            s_d.cnt = '0;
                        end else begin
                            s_d.cnt = s_q.cnt + CNT_W'(1);
                        end
                    end
                end
                PH_DATA: begin
                    if (frame_done) begin
                        if (go) begin
                            s_d.ph  = PH_HDR;
                            s_d.cnt = '0;
                            s_d.hdr = fresh_hdr;
                            s_d.mdo = fresh_hdr[HDR_BITS-1];
                            s_d.oe  = 1'b1;
                        end else begin
                            s_d.ph  = PH_IDLE;
                            s_d.cnt = '0;
                        end
                    end else if (fall_tick) begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
                default: s_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, hdr: '0, rx: '0, mdo: 1'b0, oe: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mdio_o  = s_q.mdo;
    assign mdio_oe = s_q.oe;
    assign rx_word = s_q.rx;

endmodule

// File: rtl/status_tracker.sv
module status_tracker #(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned LINK_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] status_word,
    output logic              status_chg,
    output logic              link_up
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              chg;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (frame_done) begin
            st_d.word = rx_word;
            st_d.chg  = (rx_word != st_q.word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_word = st_q.word;
    assign status_chg  = st_q.chg;
    assign link_up     = st_q.word[LINK_BIT];

endmodule

// File: rtl/mdio_autopoll.sv
module mdio_autopoll
    import mdio_poll_pkg::*;
#(
    parameter int unsigned MDC_DIV  = 40,
    parameter int unsigned GAP_SEL_W = 3,
    parameter int unsigned POLL_REG = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 poll_en,
    input  logic [ADDR_W-1:0]    phy_addr,
    input  logic [GAP_SEL_W-1:0] gap_sel,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i,
    output logic [DATA_W-1:0]    status_word,
    output logic                 status_chg,
    output logic                 link_up
);

    logic rise_tick;
    logic fall_tick;
    logic go;
    logic frame_done;
    logic [DATA_W-1:0] rx_word;

    mdc_divider #(.DIV(MDC_DIV)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (poll_en),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    poll_gap_timer #(.SEL_W(GAP_SEL_W), .BASE_LOG2(4)) gap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (poll_en),
        .fall_tick  (fall_tick),
        .frame_done (frame_done),
        .gap_sel    (gap_sel),
        .go         (go)
    );

    mdio_frame_seq #(.POLL_REG(POLL_REG)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (poll_en),
        .go         (go),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .phy_addr   (phy_addr),
        .mdio_i     (mdio_i),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .frame_done (frame_done),
        .rx_word    (rx_word)
    );

    status_tracker #(.WORD_W(DATA_W), .LINK_BIT(2)) stat_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .rx_word     (rx_word),
        .status_word (status_word),
        .status_chg  (status_chg),
        .link_up     (link_up)
    );

endmodule

// File: rtl/mdio_autopoll_chk.sv
module mdio_autopoll_chk #(
    parameter int unsigned MDC_DIV = 40
) (
    input logic        clk,
    input logic        rst_n,
    input logic        poll_en,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [15:0] status_word,
    input logic        status_chg
);

    localparam int unsigned HW = $clog2(MDC_DIV + 1);

    logic [HW-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (mdc) begin
            hi_q <= hi_q + HW'(1);
        end else begin
            hi_q <= '0;
        end
    end

    // R1
    quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_en |=> (!mdc && !mdio_oe));

    // R3
    mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mdio_o != $past(mdio_o)) || (mdio_oe != $past(mdio_oe))) |-> !mdc);

    // R2
    mdc_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mdc) && $past(poll_en)) |-> (hi_q == HW'(MDC_DIV / 2)));

    // R7
    chg_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_chg |-> (status_word != $past(status_word)));

    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_chg |-> $stable(status_word));

endmodule

bind mdio_autopoll mdio_autopoll_chk #(.MDC_DIV(MDC_DIV)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_en     (poll_en),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .status_word (status_word),
    .status_chg  (status_chg)
);

// File: tb/mdio_autopoll_tb_top.sv
module mdio_autopoll_tb_top;

    localparam int DIV = 4;
    localparam int WDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll_en = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [2:0]  gap_sel = '0;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;
    logic [15:0] status_word;
    logic        status_chg;
    logic        link_up;

    always #5 clk = ~clk;

    mdio_autopoll #(.MDC_DIV(DIV), .GAP_SEL_W(3), .POLL_REG(1)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll_en     (poll_en),
        .phy_addr    (phy_addr),
        .gap_sel     (gap_sel),
        .mdc         (mdc),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .mdio_i      (mdio_i),
        .status_word (status_word),
        .status_chg  (status_chg),
        .link_up     (link_up)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc = 0;

    // Vector: {gap code[23:21], PHY address[20:16], reply word[15:0]}
    localparam logic [23:0] VECS [8] = '{
        {3'd1, 5'd3,  16'h782D},
        {3'd0, 5'd17, 16'h782D},
        {3'd2, 5'd0,  16'h7809},
        {3'd3, 5'd31, 16'h0004},
        {3'd7, 5'd9,  16'hFFFF},
        {3'd4, 5'd22, 16'hFFFF},
        {3'd5, 5'd5,  16'h0000},
        {3'd6, 5'd12, 16'hA5A5}
    };

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    // PHY model
    logic [15:0] phy_word = '0;
    logic [15:0] cur_word = '0;
    logic [45:0] hdr = '0;
    logic [45:0] last_hdr = '0;
    int hbits = 0;
    int post = 100;
    int gap_seen = -1;
    int hdr_cnt = 0;
    int mdc_rises = 0;
    int last_rise = 0;
    int period = 0;
    int hi_time = 0;

    always @(posedge mdc) begin
        mdc_rises++;
        period = cyc - last_rise;
        last_rise = cyc;
        if (mdio_oe) begin
            if (hbits == 0) gap_seen = post - 18;
            hdr = {hdr[44:0], mdio_o};
            hbits++;
        end else begin
            if (hbits == 46) begin
                last_hdr = hdr;
                cur_word = phy_word;
                hdr_cnt++;
                post = 1;
            end else begin
                post++;
            end
            hbits = 0;
        end
    end

    always @(negedge mdc) begin
        int nxt;
        hi_time = cyc - last_rise;
        nxt = post + 1;
        if (hbits == 0 && nxt >= 3 && nxt <= 18) mdio_i = cur_word[18 - nxt];
        else mdio_i = 1'b1;
    end

    // R3 monitor on the pins
    int viol = 0;
    logic p_o = 1'b0;
    logic p_oe = 1'b0;
    int chg_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if ((mdio_o !== p_o || mdio_oe !== p_oe) && mdc) viol++;
            if (status_chg) chg_cnt++;
        end
        p_o = mdio_o;
        p_oe = mdio_oe;
    end

    function automatic int exp_gap(input logic [2:0] s);
        return (s == 0) ? 0 : (1 << (int'(s) + 4));
    endfunction

    task automatic wait_hdr(input int target);
        while (hdr_cnt < target) @(negedge clk);
    endtask

    initial begin
        logic [15:0] prev_word;
        int rises0;
        int c0;
        int h0;

        repeat (3) @(negedge clk);
        // R11
        chk("R11", "mdc", mdc, 0);
        chk("R11", "mdio_oe", mdio_oe, 0);
        chk("R11", "mdio_o", mdio_o, 0);
        chk("R11", "status_word", status_word, 0);
        chk("R11", "status_chg", status_chg, 0);
        chk("R11", "link_up", link_up, 0);

        rst_n = 1'b1;
        rises0 = mdc_rises;
        repeat (200) @(negedge clk);
        // R1
        chk("R1", "mdc rises while off", mdc_rises - rises0, 0);
        chk("R1", "mdio_oe while off", mdio_oe, 0);

        gap_sel  = VECS[0][23:21];
        phy_addr = VECS[0][20:16];
        phy_word = VECS[0][15:0];
        poll_en  = 1'b1;
        @(negedge clk);
        // R10
        chk("R10", "start oe/o/mdc", {mdio_oe, mdio_o, mdc}, 3'b110);

        prev_word = '0;
        for (int i = 0; i < 8; i++) begin
            logic [2:0]  s;
            logic [4:0]  p;
            logic [15:0] w;
            s = VECS[i][23:21];
            p = VECS[i][20:16];
            w = VECS[i][15:0];
            gap_sel  = s;
            phy_addr = p;
            phy_word = w;
            c0 = chg_cnt;
            h0 = hdr_cnt;
            wait_hdr(h0 + 2);
            // R5
            chk("R5", "status_word", status_word, w);
            // R8
            chk("R8", "link_up", link_up, w[2]);
            // R4
            chk("R4", "header", last_hdr, {32'hFFFF_FFFF, 2'b01, 2'b10, p, 5'd1});
            // R6
            chk("R6", "gap rises", gap_seen, exp_gap(s));
            // R7
            chk("R7", "change pulses", chg_cnt - c0, (w != prev_word) ? 1 : 0);
            prev_word = w;
        end

        // R2
        chk("R2", "mdc period", period, DIV);
        chk("R2", "mdc high time", hi_time, DIV / 2);
        // R3
        chk("R3", "mdio moves while mdc high", viol, 0);

        // R9 abort in the data field
        gap_sel  = 3'd0;
        phy_word = 16'h1234;
        c0 = chg_cnt;
        while (!(hbits == 0 && post == 10)) @(negedge clk);
        poll_en = 1'b0;
        @(negedge clk);
        chk("R9", "mdc/oe after abort", {mdc, mdio_oe}, 2'b00);
        repeat (300) @(negedge clk);
        chk("R9", "status kept", status_word, 16'hA5A5);
        chk("R9", "no change pulse", chg_cnt - c0, 0);

        poll_en = 1'b1;
        @(negedge clk);
        // R10
        chk("R10", "restart oe/o/mdc", {mdio_oe, mdio_o, mdc}, 3'b110);
        h0 = hdr_cnt;
        wait_hdr(h0 + 2);
        // R5
        chk("R5", "word after restart", status_word, 16'h1234);
        // R8
        chk("R8", "link after restart", link_up, 1'b1);

        summary();
        $finish;
    end

endmodule